// File: doc/BRIEF.md
# Phase Error Counter with Preset

This block measures the phase error of a motor servo loop. Software sets a 20-bit start value in two write-only registers. The upper register holds the top nibble and the lower register holds the remaining 16 bits. Writing the upper register only stages its byte. A full-word write to the lower register moves the staged nibble and the new low word together into a preset holding register.

Each reference pulse loads the holding register into a 20-bit up-counter. The counter then advances once per tick of a prescaler, which divides the servo clock by 1, 2, 4 or 8. The start value is picked so that the counter reaches mid-scale (20'h80000) when the feedback edge arrives exactly on target.

Each feedback pulse samples the counter and subtracts mid-scale modulo 2^20. The result is a two's-complement signed error, so zero error reads as zero. A one-cycle valid strobe accompanies each new error value.

Top module: `phase_err_counter`

## Requirements
- R1: A write to the upper register (wr_sel=0, wr_be[0]=1, data in wr_data[7:0]) stages that byte only. The committed preset does not change.
- R2: A lower-register write with wr_sel=1 and wr_be=2'b11 commits preset = {staged upper bits [3:0], wr_data[15:0]} in that clock edge.
- R3: A lower-register write that is not preceded by a new upper write reuses the nibble already staged.
- R4: A lower-register write with wr_be of 2'b01 or 2'b10 is ignored. Both the committed preset and the staged low word keep their values.
- R5: Reads of the preset registers are not supported. rd_data is always zero.
- R6: After reset, and after any cycle with standby high, the following hold:
  - The upper register holds 8'hF0.
  - The lower register holds 16'h0000.
  - The committed preset is 20'h00000.
  - The counter, the error register and err_valid are zero.
- R7: ref_pulse loads the committed preset into the counter. The counter then holds preset + floor(m / 2^div_sel) m edges later, with div_sel 0..3 selecting divide by 1, 2, 4 or 8.
- R8: At an edge where fb_pulse is high, err_data captures (count - 20'h80000) mod 2^20, and err_valid is high for exactly the following cycle.
- R9: If ref_pulse and fb_pulse are high in the same cycle, the capture uses the count from before the reload.
- R10: The counter wraps from 20'hFFFFF to 20'h00000 without saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Servo clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous clear to the reset state |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the upper register, 1 selects the lower register |
| wr_be | input | 2 | Byte-lane enables |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, always zero |
| div_sel | input | 2 | Prescaler select: divide by 2^div_sel |
| ref_pulse | input | 1 | Reference event, loads the preset |
| fb_pulse | input | 1 | Feedback event, captures the error |
| count | output | 20 | Current counter value |
| err_data | output | 20 | Signed phase error referenced to zero |
| err_valid | output | 1 | One-cycle strobe on a new error |

## Verification
The bench builds the block with its default parameters: a 20-bit count, a 16-bit lower register and a 2-bit divide select. With these, every divide ratio from 1 to 8 can be selected. The full 20-bit range also lets a preset near the top of the range reach the wrap within a few cycles. The stimulus table covers each ratio together with positive, zero, negative and wrapped errors. Directed cases follow for staging, byte-lane rejection, standby and coincident reference and feedback pulses.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int CNT_W    = 20;
  localparam int LO_W     = 16;
  localparam int HI_REG_W = 8;
  localparam int SEL_W    = 2;
  localparam logic [HI_REG_W-1:0] HI_RST = 8'hF0;
endpackage

// File: rtl/pec_preset_regs.sv
module pec_preset_regs #(
  parameter int CNT_W    = pec_pkg::CNT_W,
  parameter int LO_W     = pec_pkg::LO_W,
  parameter int HI_REG_W = pec_pkg::HI_REG_W,
  parameter logic [HI_REG_W-1:0] HI_RST = pec_pkg::HI_RST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [1:0]       wr_be,
  input  logic [LO_W-1:0]  wr_data,
  output logic [CNT_W-1:0] preset
);
  localparam int HI_W = CNT_W - LO_W;
  localparam logic [CNT_W-1:0] PRESET_RST = {HI_RST[HI_W-1:0], {LO_W{1'b0}}};

  logic [HI_REG_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0]     lo_q, lo_d;
  logic [CNT_W-1:0]    pre_q, pre_d;
  logic                hi_wr, lo_wr;

  // Upper register: byte lane 0 only. Lower register: both lanes required.
  assign hi_wr = wr_en & ~wr_sel & wr_be[0];
  assign lo_wr = wr_en &  wr_sel & (&wr_be);

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    pre_d = pre_q;
    if (standby) begin
      hi_d  = HI_RST;
      lo_d  = '0;
      pre_d = PRESET_RST;
    end else begin
      if (hi_wr) hi_d = wr_data[HI_REG_W-1:0];
      if (lo_wr) begin
        lo_d  = wr_data;
        pre_d = {hi_q[HI_W-1:0], wr_data};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= HI_RST;
      lo_q  <= '0;
      pre_q <= PRESET_RST;
    end else begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      pre_q <= pre_d;
    end
  end

  assign preset = pre_q;
endmodule

// File: rtl/pec_prescaler.sv
module pec_prescaler #(
  parameter int SEL_W = pec_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             restart,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int PS_W = (1 << SEL_W) - 1;

  logic [PS_W-1:0] ps_q, ps_d;
  logic [PS_W-1:0] mask;

  // mask = 2^div_sel - 1; a tick is issued when the phase reaches mask
  always_comb begin
    mask = '0;
    for (int i = 0; i < PS_W; i++) begin
      if (i < int'(div_sel)) mask[i] = 1'b1;
    end
  end

  assign tick = ~restart & ~standby & ((ps_q & mask) == mask);

  always_comb begin
    if (standby || restart) ps_d = '0;
    else                    ps_d = ps_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_d;
  end
endmodule

// File: rtl/pec_counter.sv
module pec_counter #(
  parameter int CNT_W = pec_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  input  logic             tick,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] err_data,
  output logic             err_valid
);
  localparam logic [CNT_W-1:0] MID = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q, cnt_d, err_q, err_d;
  logic             vld_q, vld_d;

  always_comb begin
    cnt_d = cnt_q;
    err_d = err_q;
    vld_d = 1'b0;
    if (standby) begin
      cnt_d = '0;
      err_d = '0;
    end else begin
      // capture samples the pre-update count, so it wins over a reload
      if (fb_pulse) begin
        err_d = cnt_q - MID;
        vld_d = 1'b1;
      end
      if (ref_pulse)  cnt_d = preset;
      else if (tick)  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
      vld_q <= vld_d;
    end
  end

  assign count     = cnt_q;
  assign err_data  = err_q;
  assign err_valid = vld_q;
endmodule

// File: rtl/phase_err_counter.sv
module phase_err_counter #(
  parameter int CNT_W    = pec_pkg::CNT_W,
  parameter int LO_W     = pec_pkg::LO_W,
  parameter int HI_REG_W = pec_pkg::HI_REG_W,
  parameter int SEL_W    = pec_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [1:0]       wr_be,
  input  logic [LO_W-1:0]  wr_data,
  output logic [LO_W-1:0]  rd_data,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] err_data,
  output logic             err_valid
);
  logic [CNT_W-1:0] preset_w;
  logic             tick_w;

  assign rd_data = '0;

  pec_preset_regs #(
    .CNT_W(CNT_W), .LO_W(LO_W), .HI_REG_W(HI_REG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be), .wr_data(wr_data),
    .preset(preset_w)
  );

  pec_prescaler #(.SEL_W(SEL_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .restart(ref_pulse), .div_sel(div_sel), .tick(tick_w)
  );

  pec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .tick(tick_w),
    .preset(preset_w), .count(count), .err_data(err_data),
    .err_valid(err_valid)
  );
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             standby,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [1:0]       wr_be,
  input logic             ref_pulse,
  input logic             fb_pulse,
  input logic [CNT_W-1:0] preset,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] err_data,
  input logic             err_valid
);
  localparam logic [CNT_W-1:0] MID = {1'b1, {(CNT_W-1){1'b0}}};

  AST_HI_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !standby) |=> $stable(preset)); // R1

  AST_PART_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_be != 2'b11 && !standby) |=> $stable(preset)); // R4

  AST_STANDBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (count == '0 && err_valid == 1'b0 && preset == '0)); // R6

  AST_REF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && !standby) |=> count == $past(preset)); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_pulse && !standby) |=>
      (count == $past(count) || count == $past(count) + 1'b1)); // R10

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && !standby) |=> (err_valid && err_data == $past(count) - MID)); // R9

  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(fb_pulse)); // R8
endmodule

bind phase_err_counter pec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
  .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .preset(preset_w),
  .count(count), .err_data(err_data), .err_valid(err_valid)
);

// File: tb/tb_phase_err_counter.sv
module tb_phase_err_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 20;
  localparam logic [CW-1:0] MID = 20'h80000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          standby = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [1:0]    wr_be = 2'b00;
  logic [15:0]   wr_data = '0;
  logic [15:0]   rd_data;
  logic [1:0]    div_sel = 2'd0;
  logic          ref_pulse = 1'b0;
  logic          fb_pulse = 1'b0;
  logic [CW-1:0] count, err_data;
  logic          err_valid;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_err_counter dut (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .div_sel(div_sel), .ref_pulse(ref_pulse),
    .fb_pulse(fb_pulse), .count(count), .err_data(err_data),
    .err_valid(err_valid)
  );

  // vector: {div_sel[1:0], preset[19:0], span[15:0]}
  localparam int NV = 6;
  localparam logic [37:0] VECS [NV] = '{
    {2'd0, 20'h7FFF6, 16'd11},
    {2'd1, 20'h7FF00, 16'd21},
    {2'd2, 20'h80010, 16'd9},
    {2'd3, 20'h12345, 16'd40},
    {2'd0, 20'hFFFFE, 16'd5},
    {2'd1, 20'h00000, 16'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic load_preset(input logic [CW-1:0] p);
    wr(1'b0, 2'b01, {8'h00, 4'h0, p[19:16]});
    wr(1'b1, 2'b11, p[15:0]);
  endtask

  // ref at edge E0, fb at edge E0+span; returns captured error
  task automatic measure(input logic [1:0] sel, input int span, input string req,
                         input logic [CW-1:0] exp_preset);
    logic [CW-1:0] exp_err;
    div_sel = sel;
    ref_pulse = 1'b1;
    @(negedge clk);
    ref_pulse = 1'b0;
    check({req, "/R7 load"}, 32'(count), 32'(exp_preset));
    repeat (span - 1) @(negedge clk);
    fb_pulse = 1'b1;
    @(negedge clk);
    fb_pulse = 1'b0;
    exp_err = exp_preset + CW'((span - 1) >> sel) - MID;
    check({req, "/R8 valid"}, 32'(err_valid), 32'd1);
    check({req, "/R8 err"}, 32'(err_data), 32'(exp_err));
    @(negedge clk);
    check({req, "/R8 strobe width"}, 32'(err_valid), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    check("R6 count", 32'(count), 32'd0);
    check("R6 err", 32'(err_data), 32'd0);
    check("R6 valid", 32'(err_valid), 32'd0);
    check("R5 rd", 32'(rd_data), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 default preset 0 held before any lower write
    measure(2'd0, 3, "R6 default", 20'h00000);

    // table walk: R2, R7, R8, R10 (entry 5 wraps)
    for (int i = 0; i < NV; i++) begin
      load_preset(VECS[i][35:16]);
      measure(VECS[i][37:36], int'(VECS[i][15:0]), "R2/R10 table", VECS[i][35:16]);
    end

    // R1: upper write alone leaves preset untouched
    load_preset(20'h3_1234);
    wr(1'b0, 2'b01, 16'h0009);
    measure(2'd0, 4, "R1 stage only", 20'h3_1234);
    // R3: lower write reuses staged nibble 9
    wr(1'b1, 2'b11, 16'hABCD);
    measure(2'd0, 4, "R3 reuse nibble", 20'h9_ABCD);
    // R4: byte-lane writes to lower ignored
    wr(1'b1, 2'b01, 16'h1111);
    wr(1'b1, 2'b10, 16'h2222);
    measure(2'd0, 4, "R4 partial", 20'h9_ABCD);
    check("R5 rd after writes", 32'(rd_data), 32'd0);

    // R9: coincident ref and fb capture the pre-reload count
    load_preset(20'h8_0000);
    div_sel = 2'd0;
    ref_pulse = 1'b1;
    @(negedge clk);
    ref_pulse = 1'b0;
    repeat (5) @(negedge clk);           // count = 0x80005
    ref_pulse = 1'b1; fb_pulse = 1'b1;
    @(negedge clk);
    ref_pulse = 1'b0; fb_pulse = 1'b0;
    check("R9 err", 32'(err_data), 32'h00005);
    check("R9 reload", 32'(count), 32'h80000);

    // R10 wrap seen directly on count
    load_preset(20'hFFFFF);
    ref_pulse = 1'b1;
    @(negedge clk);
    ref_pulse = 1'b0;
    @(negedge clk);
    check("R10 wrap", 32'(count), 32'h00000);

    // R6 standby clears preset, staging and counter
    wr(1'b0, 2'b01, 16'h0005);
    standby = 1'b1;
    @(negedge clk);
    standby = 1'b0;
    check("R6 standby count", 32'(count), 32'd0);
    wr(1'b1, 2'b11, 16'h0010);           // staged nibble is 0 from 0xF0
    measure(2'd2, 9, "R6 standby", 20'h0_0010);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule